// File: doc/BRIEF.md
# Program Memory Table-Access Guard

This block sits between a processor's table-access unit and a 32 KB program flash. Each table read or table write carries a target address and the program counter of the instruction that issued it. The guard splits program memory into a small boot region and four equal user regions. For every access it looks up that region's protection bits, then either forwards the access or refuses it. A refused write never reaches the flash. A refused read returns zeros in place of the stored byte.

The guard also keeps the protection configuration: one write-protect bit, one read-protect bit and one code-protect bit per region. Software can clear these bits but can never set them. Only an erase command from the external programming port returns them to 1. On reset the bits are loaded from a non-volatile shadow input. Code-protect bits are held and visible here, but they only matter to the external programmer, so they never affect user-mode table accesses.

Results are registered. The write strobe to the flash, the read data and the two one-cycle status flags all appear on the clock edge that follows the request cycle. The read data is taken from `flash_rdata`, which the flash presents combinationally for `acc_addr` during the request cycle.

Top module: `pmem_guard`

## Requirements
- R1: Region decode. Index 0 is the boot region, 0x000000–0x0001FF. Index 1 is 0x000200–0x001FFF, index 2 is 0x002000–0x003FFF, index 3 is 0x004000–0x005FFF and index 4 is 0x006000–0x007FFF. Bit k of every protection vector belongs to region index k.
- R2: A table write to a region whose write-protect bit is 0 is refused whatever its program counter is. `flash_we` stays 0 and `write_denied` pulses. A write to a region whose write-protect bit is 1 drives `flash_we`=1 with the request's address and data.
- R3: A table read of a region whose read-protect bit is 0 returns the flash byte when the program counter lies in that same region. A read of a region whose read-protect bit is 1 returns the flash byte from any program counter.
- R4: A table read of a read-protected region from a program counter outside it returns all zeros and pulses `read_masked`.
- R5: Code-protect bits have no effect on table reads or writes.
- R6: A configuration write (`cfg_we`=1) sets each protection vector to the old value AND the written value. Writing a 1 over a 0 has no effect.
- R7: `erase_req`=1 sets every write-, read- and code-protect bit to 1 at the next edge. It wins over a configuration write in the same cycle.
- R8: Addresses at or above 0x008000 are unimplemented. Reads there return zero and pulse `read_masked`. Writes there are dropped and pulse `write_denied`.
- R9: While `rst_n`=0 the protection vectors load from `nv_wp`, `nv_rp` and `nv_cp`, and all access outputs are 0.
- R10: Every access result appears exactly one cycle after its request. `rd_valid`, `flash_we`, `write_denied` and `read_masked` are 0 in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_wp | input | 5 | Shadow write-protect bits loaded at reset |
| nv_rp | input | 5 | Shadow read-protect bits loaded at reset |
| nv_cp | input | 5 | Shadow code-protect bits loaded at reset |
| erase_req | input | 1 | Erase command from the programming port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | 5 | Write-protect value to merge (AND) |
| cfg_rp | input | 5 | Read-protect value to merge (AND) |
| cfg_cp | input | 5 | Code-protect value to merge (AND) |
| acc_valid | input | 1 | Table access request |
| acc_write | input | 1 | 1 = table write, 0 = table read |
| acc_addr | input | 22 | Target program memory address |
| acc_pc | input | 22 | Program counter of the accessing instruction |
| acc_wdata | input | 8 | Write data |
| flash_rdata | input | 8 | Flash byte at acc_addr, valid in the request cycle |
| flash_we | output | 1 | Write strobe to flash |
| flash_addr | output | 22 | Flash write address |
| flash_wdata | output | 8 | Flash write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result (zero when masked) |
| write_denied | output | 1 | One-cycle flag: write refused |
| read_masked | output | 1 | One-cycle flag: read returned zeros |
| prot_wp | output | 5 | Current write-protect bits |
| prot_rp | output | 5 | Current read-protect bits |
| prot_cp | output | 5 | Current code-protect bits |

## Verification
The bench probes the region edges at 0x01FF/0x0200, 0x1FFF/0x2000 and 0x8000. A decoder that is off by one there would apply the wrong region's bits, or would let a write into unimplemented space. Reads of a read-protected region are issued from a program counter inside it, from a neighbouring region and from the boot region. A guard that ignored the program counter would either leak data or mask a legal read. It also writes 1s over cleared bits, and raises an erase together with a clearing configuration write. A register that merged by OR, or that ranked the erase below the configuration write, would show the wrong `prot_*` value. Finally, a write-protected region is written from a program counter inside that region, which catches a guard that wrongly exempts same-region writes.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

    // Verdict produced by the policy stage for one access
    typedef struct packed {
        logic rd_grant;
        logic wr_grant;
        logic wr_deny;
        logic rd_mask;
    } verdict_t;

    localparam int DEF_ADDR_W    = 22;
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_N_USER    = 4;
    localparam int DEF_BLK_SHIFT = 13;
    localparam int DEF_BOOT_SIZE = 512;

endpackage

// File: rtl/pmg_region_dec.sv
module pmg_region_dec #(
    parameter int ADDR_W    = 22,
    parameter int N_USER    = 4,
    parameter int BLK_SHIFT = 13,
    parameter int BOOT_SIZE = 512,
    localparam int N_REG    = N_USER + 1,
    localparam int RW       = $clog2(N_REG + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [RW-1:0]     region,
    output logic              unimpl
);

    localparam logic [ADDR_W-1:0] MEM_TOP  = ADDR_W'(N_USER) << BLK_SHIFT;
    localparam logic [ADDR_W-1:0] BOOT_TOP = ADDR_W'(BOOT_SIZE);

    logic [ADDR_W-1:0] blk_num;

    always_comb begin
        blk_num = addr >> BLK_SHIFT;
        if (addr >= MEM_TOP) begin
            region = RW'(N_REG);
            unimpl = 1'b1;
        end else if (addr < BOOT_TOP) begin
            region = '0;
            unimpl = 1'b0;
        end else begin
            region = RW'(blk_num) + RW'(1);
            unimpl = 1'b0;
        end
    end

    // R1: an implemented address always maps to a real region index
    always_comb begin
        if (!unimpl) begin
            assert_region_in_range_R1: assert (region < RW'(N_REG));
        end
    end

endmodule

// File: rtl/pmg_cfg_reg.sv
module pmg_cfg_reg #(
    parameter int NB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] nv_wp,
    input  logic [NB-1:0] nv_rp,
    input  logic [NB-1:0] nv_cp,
    input  logic          erase_req,
    input  logic          cfg_we,
    input  logic [NB-1:0] cfg_wp,
    input  logic [NB-1:0] cfg_rp,
    input  logic [NB-1:0] cfg_cp,
    output logic [NB-1:0] prot_wp,
    output logic [NB-1:0] prot_rp,
    output logic [NB-1:0] prot_cp
);

    typedef struct packed {
        logic [NB-1:0] wp;
        logic [NB-1:0] rp;
        logic [NB-1:0] cp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (erase_req) begin
            cfg_d.wp = '1;
            cfg_d.rp = '1;
            cfg_d.cp = '1;
        end else if (cfg_we) begin
            cfg_d.wp = cfg_q.wp & cfg_wp;
            cfg_d.rp = cfg_q.rp & cfg_rp;
            cfg_d.cp = cfg_q.cp & cfg_cp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.wp <= nv_wp;
            cfg_q.rp <= nv_rp;
            cfg_q.cp <= nv_cp;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign prot_wp = cfg_q.wp;
    assign prot_rp = cfg_q.rp;
    assign prot_cp = cfg_q.cp;

    // R6: without an erase, no protection bit ever rises
    assert_no_bit_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_req |=> ((cfg_q & ~$past(cfg_q)) == '0));

    // R7: erase drives every bit to 1 regardless of a configuration write
    assert_erase_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> (&prot_wp && &prot_rp && &prot_cp));

    // R6: a configuration write clears exactly the bits written as 0
    assert_cfg_and_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !erase_req) |=> (prot_wp == ($past(prot_wp) & $past(cfg_wp))));

endmodule

// File: rtl/pmg_policy.sv
module pmg_policy
    import pmg_pkg::*;
#(
    parameter int NB = 5,
    localparam int RW = $clog2(NB + 1)
) (
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [RW-1:0] addr_region,
    input  logic          addr_unimpl,
    input  logic [RW-1:0] pc_region,
    input  logic [NB-1:0] wp,
    input  logic [NB-1:0] rp,
    output verdict_t      verdict
);

    logic wp_bit;
    logic rp_bit;
    logic same_blk;
    logic rd_ok;
    logic wr_ok;

    // Select the protection bits of the target region
    always_comb begin
        wp_bit = 1'b0;
        rp_bit = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (addr_region == RW'(i)) begin
                wp_bit = wp[i];
                rp_bit = rp[i];
            end
        end
    end

    always_comb begin
        same_blk = (pc_region == addr_region) && !addr_unimpl;
        wr_ok    = !addr_unimpl && wp_bit;
        rd_ok    = !addr_unimpl && (rp_bit || same_blk);

        verdict.wr_grant = acc_valid &&  acc_write && wr_ok;
        verdict.wr_deny  = acc_valid &&  acc_write && !wr_ok;
        verdict.rd_grant = acc_valid && !acc_write && rd_ok;
        verdict.rd_mask  = acc_valid && !acc_write && !rd_ok;
    end

    // R2/R4: at most one outcome per access
    always_comb begin
        assert_single_outcome_R2: assert ($onehot0({verdict.rd_grant, verdict.wr_grant,
                                                    verdict.wr_deny, verdict.rd_mask}));
    end

endmodule

// File: rtl/pmem_guard.sv
module pmem_guard
    import pmg_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int N_USER    = DEF_N_USER,
    parameter int BLK_SHIFT = DEF_BLK_SHIFT,
    parameter int BOOT_SIZE = DEF_BOOT_SIZE,
    localparam int NB       = N_USER + 1,
    localparam int RW       = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     nv_wp,
    input  logic [NB-1:0]     nv_rp,
    input  logic [NB-1:0]     nv_cp,
    input  logic              erase_req,
    input  logic              cfg_we,
    input  logic [NB-1:0]     cfg_wp,
    input  logic [NB-1:0]     cfg_rp,
    input  logic [NB-1:0]     cfg_cp,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] acc_pc,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic              flash_we,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              write_denied,
    output logic              read_masked,
    output logic [NB-1:0]     prot_wp,
    output logic [NB-1:0]     prot_rp,
    output logic [NB-1:0]     prot_cp
);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              wdeny;
        logic              rmask;
    } out_t;

    out_t out_d, out_q;

    // Region decode for the target address (0) and the program counter (1)
    logic [ADDR_W-1:0] dec_in     [2];
    logic [RW-1:0]     dec_region [2];
    logic              dec_unimpl [2];

    assign dec_in[0] = acc_addr;
    assign dec_in[1] = acc_pc;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        pmg_region_dec #(
            .ADDR_W    (ADDR_W),
            .N_USER    (N_USER),
            .BLK_SHIFT (BLK_SHIFT),
            .BOOT_SIZE (BOOT_SIZE)
        ) u_dec (
            .addr   (dec_in[g]),
            .region (dec_region[g]),
            .unimpl (dec_unimpl[g])
        );
    end

    logic pc_unimpl_unused;
    assign pc_unimpl_unused = dec_unimpl[1];

    pmg_cfg_reg #(.NB(NB)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_wp     (nv_wp),
        .nv_rp     (nv_rp),
        .nv_cp     (nv_cp),
        .erase_req (erase_req),
        .cfg_we    (cfg_we),
        .cfg_wp    (cfg_wp),
        .cfg_rp    (cfg_rp),
        .cfg_cp    (cfg_cp),
        .prot_wp   (prot_wp),
        .prot_rp   (prot_rp),
        .prot_cp   (prot_cp)
    );

    verdict_t verdict;

    pmg_policy #(.NB(NB)) u_policy (
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .addr_region (dec_region[0]),
        .addr_unimpl (dec_unimpl[0]),
        .pc_region   (dec_region[1]),
        .wp          (prot_wp),
        .rp          (prot_rp),
        .verdict     (verdict)
    );

    always_comb begin
        out_d        = '0;
        out_d.we     = verdict.wr_grant;
        out_d.addr   = verdict.wr_grant ? acc_addr  : '0;
        out_d.wdata  = verdict.wr_grant ? acc_wdata : '0;
        out_d.rvalid = verdict.rd_grant || verdict.rd_mask;
        out_d.rdata  = verdict.rd_grant ? flash_rdata : '0;
        out_d.wdeny  = verdict.wr_deny;
        out_d.rmask  = verdict.rd_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign flash_we     = out_q.we;
    assign flash_addr   = out_q.addr;
    assign flash_wdata  = out_q.wdata;
    assign rd_valid     = out_q.rvalid;
    assign rd_data      = out_q.rdata;
    assign write_denied = out_q.wdeny;
    assign read_masked  = out_q.rmask;

    // R2: a write into a region with write-protect 0 never reaches the flash
    assert_wp_blocks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !dec_unimpl[0] && (prot_wp == '0))
        |=> (!flash_we && write_denied));

    // R4: a masked read carries zero data
    assert_masked_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        read_masked |-> (rd_valid && rd_data == '0));

    // R8: unimplemented target address never produces a flash write
    assert_unimpl_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && dec_unimpl[0]) |=> !flash_we);

    // R10: no request means no result in the following cycle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(flash_we || rd_valid || write_denied || read_masked));

endmodule

// File: tb/pmem_guard_bench.sv
module pmem_guard_bench;

    localparam int AW = 22;
    localparam int DW = 8;
    localparam int NB = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NB-1:0] nv_wp, nv_rp, nv_cp;
    logic          erase_req, cfg_we;
    logic [NB-1:0] cfg_wp, cfg_rp, cfg_cp;
    logic          acc_valid, acc_write;
    logic [AW-1:0] acc_addr, acc_pc;
    logic [DW-1:0] acc_wdata, flash_rdata;
    logic          flash_we, rd_valid, write_denied, read_masked;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_wdata, rd_data;
    logic [NB-1:0] prot_wp, prot_rp, prot_cp;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    // Flash model: byte derived from the address, presented combinationally
    assign flash_rdata = acc_addr[7:0] ^ acc_addr[15:8] ^ 8'hA5;

    function automatic logic [DW-1:0] fbyte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    pmem_guard u_pmem_guard (
        .clk (clk), .rst_n (rst_n),
        .nv_wp (nv_wp), .nv_rp (nv_rp), .nv_cp (nv_cp),
        .erase_req (erase_req), .cfg_we (cfg_we),
        .cfg_wp (cfg_wp), .cfg_rp (cfg_rp), .cfg_cp (cfg_cp),
        .acc_valid (acc_valid), .acc_write (acc_write),
        .acc_addr (acc_addr), .acc_pc (acc_pc), .acc_wdata (acc_wdata),
        .flash_rdata (flash_rdata),
        .flash_we (flash_we), .flash_addr (flash_addr), .flash_wdata (flash_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .write_denied (write_denied), .read_masked (read_masked),
        .prot_wp (prot_wp), .prot_rp (prot_rp), .prot_cp (prot_cp)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one access, wait for the registering edge, then sample
    task automatic do_access(input logic wr, input logic [AW-1:0] a,
                             input logic [AW-1:0] pc, input logic [DW-1:0] d);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = a;
        acc_pc    = pc;
        acc_wdata = d;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [AW-1:0] a,
                                input logic [AW-1:0] pc, input logic [DW-1:0] d,
                                input logic ok);
        do_access(1'b1, a, pc, d);
        check(req, "flash_we", 32'(flash_we), 32'(ok));
        check(req, "write_denied", 32'(write_denied), 32'(!ok));
        if (ok) begin
            check(req, "flash_addr", 32'(flash_addr), 32'(a));
            check(req, "flash_wdata", 32'(flash_wdata), 32'(d));
        end
    endtask

    task automatic expect_read(input string req, input logic [AW-1:0] a,
                               input logic [AW-1:0] pc, input logic ok);
        do_access(1'b0, a, pc, '0);
        check(req, "rd_valid", 32'(rd_valid), 32'd1);
        check(req, "rd_data", 32'(rd_data), ok ? 32'(fbyte(a)) : 32'd0);
        check(req, "read_masked", 32'(read_masked), 32'(!ok));
    endtask

    task automatic cfg_write(input logic er, input logic we,
                             input logic [NB-1:0] w, input logic [NB-1:0] r,
                             input logic [NB-1:0] c);
        erase_req = er;
        cfg_we    = we;
        cfg_wp    = w;
        cfg_rp    = r;
        cfg_cp    = c;
        @(posedge clk);
        #1;
        erase_req = 1'b0;
        cfg_we    = 1'b0;
    endtask

    task automatic t_reset();
        // R9: shadow values appear on the protection outputs
        check("R9", "prot_wp", 32'(prot_wp), 32'(5'b11011));
        check("R9", "prot_rp", 32'(prot_rp), 32'(5'b11101));
        check("R9", "prot_cp", 32'(prot_cp), 32'(5'b00000));
        check("R9", "outputs idle", 32'({flash_we, rd_valid, write_denied, read_masked}), 32'd0);
    endtask

    task automatic t_writes();
        // R2: region 2 write-protected, even from a PC inside region 2
        expect_write("R2", 22'h002100, 22'h002040, 8'h3C, 1'b0);
        expect_write("R2", 22'h004000, 22'h000100, 8'h5E, 1'b1);
        // R1: edges of region 1 and region 2, and top of boot region
        expect_write("R1", 22'h001FFF, 22'h000100, 8'h11, 1'b1);
        expect_write("R1", 22'h002000, 22'h000100, 8'h22, 1'b0);
        expect_write("R1", 22'h0001FF, 22'h004000, 8'h33, 1'b1);
        expect_write("R1", 22'h007FFF, 22'h000100, 8'h44, 1'b1);
    endtask

    task automatic t_reads();
        // R3: region 1 read-protected, PC inside region 1
        expect_read("R3", 22'h000300, 22'h001000, 1'b1);
        expect_read("R3", 22'h002000, 22'h006000, 1'b1);
        // R4: same region from outside: neighbour and boot
        expect_read("R4", 22'h000300, 22'h002000, 1'b0);
        expect_read("R4", 22'h001FFF, 22'h0001FE, 1'b0);
        // R1: 0x0200 is region 1 (masked), 0x01FF is boot (not masked)
        expect_read("R1", 22'h000200, 22'h0001FF, 1'b0);
        expect_read("R1", 22'h0001FF, 22'h000200, 1'b1);
    endtask

    task automatic t_unimpl();
        // R8: address 0x8000 and above
        expect_read("R8", 22'h008000, 22'h008000, 1'b0);
        expect_write("R8", 22'h008000, 22'h000100, 8'h77, 1'b0);
        expect_write("R8", 22'h3FFFFF, 22'h000100, 8'h78, 1'b0);
    endtask

    task automatic t_idle();
        // R10: a cycle with no request leaves all flags low
        do_access(1'b0, 22'h000300, 22'h002000, '0);
        check("R10", "masked pulse", 32'(read_masked), 32'd1);
        @(posedge clk);
        #1;
        check("R10", "flags after idle",
              32'({flash_we, rd_valid, write_denied, read_masked}), 32'd0);
    endtask

    task automatic t_codeprot();
        // R5: all code-protect bits are 0, accesses still follow wp/rp only
        check("R5", "cp cleared", 32'(prot_cp), 32'd0);
        expect_read("R5", 22'h006123, 22'h000010, 1'b1);
        expect_write("R5", 22'h006124, 22'h000010, 8'h9A, 1'b1);
    endtask

    task automatic t_cfg();
        // R6: writing 1s changes nothing
        cfg_write(1'b0, 1'b1, 5'b11111, 5'b11111, 5'b11111);
        check("R6", "wp ones no effect", 32'(prot_wp), 32'(5'b11011));
        check("R6", "cp ones no effect", 32'(prot_cp), 32'(5'b00000));
        // R6: clear region 3 write-protect
        cfg_write(1'b0, 1'b1, 5'b10111, 5'b11111, 5'b11111);
        check("R6", "wp cleared", 32'(prot_wp), 32'(5'b10011));
        expect_write("R6", 22'h004000, 22'h000100, 8'h5E, 1'b0);
    endtask

    task automatic t_erase();
        // R7: erase together with an all-clearing configuration write
        cfg_write(1'b1, 1'b1, 5'b00000, 5'b00000, 5'b00000);
        check("R7", "wp all ones", 32'(prot_wp), 32'(5'b11111));
        check("R7", "rp all ones", 32'(prot_rp), 32'(5'b11111));
        check("R7", "cp all ones", 32'(prot_cp), 32'(5'b11111));
        expect_write("R7", 22'h002100, 22'h000100, 8'h3C, 1'b1);
        expect_read("R7", 22'h000300, 22'h002000, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0;
        nv_wp = 5'b11011;
        nv_rp = 5'b11101;
        nv_cp = 5'b00000;
        erase_req = 1'b0;
        cfg_we    = 1'b0;
        cfg_wp = '0; cfg_rp = '0; cfg_cp = '0;
        acc_valid = 1'b0; acc_write = 1'b0;
        acc_addr = '0; acc_pc = '0; acc_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_writes();
        t_reads();
        t_unimpl();
        t_idle();
        t_codeprot();
        t_cfg();
        t_erase();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule